// File: doc/BRIEF.md
# SD Card SPI-Mode Initialiser

This block is a hardware sequencer that takes an SD card from power-up into SPI mode and learns its capacity class. No processor is involved. It does not shift bits itself. It asks an external SPI byte engine for one byte at a time: it raises `xfer_start` with the byte to send and waits for `xfer_done`, which carries the byte the card returned. The block also drives the card's chip select directly.

A pulse on `start` runs the sequence:
- Load the attempt budget.
- Send dummy bytes with chip select high.
- Send the go-idle command. Once the card answers "idle", send the interface-condition command.
- Poll the application-initialise command pair until the card reports ready.
- Send the read-OCR command. The top OCR byte is kept on `card_type`, where 80h means standard capacity and C0h means high capacity.

Two kinds of failure draw on one shared budget:
- A failed go-idle restarts the whole round, dummy bytes included.
- A not-ready answer repeats only the application-initialise pair.

When the budget runs out, the block stops with `error` high.

States:
- `S_IDLE`: waiting for `start`.
- `S_WAKE`: dummy bytes.
- `S_FRAME`: six command bytes.
- `S_POLL`: hunting for R1.
- `S_TAIL_RESP`: four trailing response bytes.
- `S_RELEASE`: one FFh with chip select high, then the decision.
- `S_DONE` and `S_FAIL`: terminal states.

Transitions:
- idle/done/fail → wake on `start`.
- wake → frame after the last dummy byte.
- frame → poll after byte six.
- poll → tail on R1 for the commands that return five bytes.
- poll → release on R1 for the others, or on timeout.
- tail → release after four bytes.
- release → frame for the next command or a repeated pair.
- release → wake for a go-idle retry.
- release → done after read-OCR.
- release → fail when the budget is spent.

Top module: `sd_spi_init`

## Requirements
- R1: After reset, and while idle, `cs_n` is 1, `xfer_start`, `done` and `error` are 0, `card_type` is 00h, and no byte transfer is requested.
- R2: Every round starts with exactly WAKE_BYTES transfers of FFh with `cs_n` high before the go-idle frame. A round that follows a failed go-idle also has the preceding trailing FFh in front of it.
- R3: Each command is six bytes sent with `cs_n` low, in this order: 01b plus the 6-bit index, a 32-bit argument MSB first, then CRC with the stop bit. The exact frames are:
  - go-idle: 40 00 00 00 00 95
  - interface-condition: 48 00 00 01 AA 87
  - app-prefix: 77 00 00 00 00 01
  - app-initialise: 69 40 00 00 00 01
  - read-OCR: 7A 00 00 00 00 01
- R4: After a frame the block sends FFh to poll, up to POLL_LIMIT bytes. It takes the first received byte with bit 7 clear as R1. If none arrives, the attempt counts as failed. For interface-condition and read-OCR, four more bytes are then clocked.
- R5: A go-idle R1 of 01h leads to interface-condition. Any other outcome uses up one attempt and restarts the round from the dummy bytes.
- R6: After interface-condition, the app-prefix/app-initialise pair is sent. An R1 of 00h leads on to read-OCR. Any other outcome uses up one attempt and repeats only the pair.
- R7: The budget holds ATTEMPTS failures. A failure that meets a budget with one attempt left ends in `S_FAIL`. `error` is then 1, `done` is 0, `cs_n` is high, and no further transfer is requested.
- R8: The first byte after the read-OCR R1 is stored in `card_type` (80h standard, C0h high capacity). After that, `done` is 1 and holds with `card_type` stable.
- R9: Every command ends with exactly one FFh sent with `cs_n` high. `cs_n` is low only during frame, poll and tail bytes.
- R10: Each byte uses one single-cycle `xfer_start`. No new request is made until `xfer_done` has answered the previous one.
- R11: `start` from idle, done or fail reloads the budget, clears `card_type` to 00h and begins a new round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the sequence (idle, done or fail) |
| cs_n | output | 1 | Card chip select, active low |
| xfer_start | output | 1 | Request one byte exchange from the SPI engine |
| xfer_tx | output | 8 | Byte to send with the request |
| xfer_done | input | 1 | Engine finished the exchange |
| xfer_rx | input | 8 | Byte received, valid with `xfer_done` |
| done | output | 1 | Initialisation succeeded |
| error | output | 1 | Attempt budget exhausted |
| card_type | output | 8 | Top OCR byte captured from read-OCR |

## Verification
The bench builds the block with ATTEMPTS = 4 and keeps the default 10 dummy bytes and 8 poll bytes. With such a small budget, every split of failures between the go-idle phase and the application-initialise phase can be swept: success with the last attempt, exhaustion while still in go-idle, and exhaustion during the pair. A card model answers each frame after a varying number of filler bytes. Go-idle failures alternate between an error R1 and total silence, which drives the poll limit.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

    typedef enum logic [2:0] {
        CMD_GO_IDLE,
        CMD_IF_COND,
        CMD_APP,
        CMD_OP_COND,
        CMD_READ_OCR
    } sd_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAKE,
        S_FRAME,
        S_POLL,
        S_TAIL_RESP,
        S_RELEASE,
        S_DONE,
        S_FAIL
    } seq_state_e;

endpackage

// File: rtl/sd_cmd_frame.sv
module sd_cmd_frame
    import sd_init_pkg::*;
(
    input  sd_cmd_e      cmd,
    input  logic [2:0]   pos,
    output logic [7:0]   frame_byte
);

    logic [5:0]  index;
    logic [31:0] arg;
    logic [7:0]  crc;

    always_comb begin
        case (cmd)
            CMD_GO_IDLE:  begin index = 6'd0;  arg = 32'h0000_0000; crc = 8'h95; end
            CMD_IF_COND:  begin index = 6'd8;  arg = 32'h0000_01AA; crc = 8'h87; end
            CMD_APP:      begin index = 6'd55; arg = 32'h0000_0000; crc = 8'h01; end
            CMD_OP_COND:  begin index = 6'd41; arg = 32'h4000_0000; crc = 8'h01; end
            CMD_READ_OCR: begin index = 6'd58; arg = 32'h0000_0000; crc = 8'h01; end
            default:      begin index = 6'd0;  arg = 32'h0000_0000; crc = 8'h01; end
        endcase
    end

    always_comb begin
        case (pos)
            3'd0:    frame_byte = {2'b01, index};
            3'd1:    frame_byte = arg[31:24];
            3'd2:    frame_byte = arg[23:16];
            3'd3:    frame_byte = arg[15:8];
            3'd4:    frame_byte = arg[7:0];
            default: frame_byte = crc;
        endcase
    end

endmodule

// File: rtl/sd_attempt_ctr.sv
module sd_attempt_ctr #(
    parameter int ATTEMPTS = 90
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic consume,
    output logic last
);

    localparam int AW = $clog2(ATTEMPTS + 1);
    localparam logic [AW-1:0] FULL = AW'(ATTEMPTS);

    logic [AW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= FULL;
        end else if (consume && left_q != '0) begin
            left_q <= left_q - AW'(1);
        end
    end

    assign last = (left_q == AW'(1));

endmodule

// File: rtl/sd_spi_init.sv
module sd_spi_init
    import sd_init_pkg::*;
#(
    parameter int ATTEMPTS   = 90,
    parameter int WAKE_BYTES = 10,
    parameter int POLL_LIMIT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       cs_n,
    output logic       xfer_start,
    output logic [7:0] xfer_tx,
    input  logic       xfer_done,
    input  logic [7:0] xfer_rx,
    output logic       done,
    output logic       error,
    output logic [7:0] card_type
);

    localparam int FRAME_LEN = 6;
    localparam int TAIL_LEN  = 4;
    localparam int BIG_A     = (WAKE_BYTES > POLL_LIMIT) ? WAKE_BYTES : POLL_LIMIT;
    localparam int CNT_MAX   = (BIG_A > FRAME_LEN) ? BIG_A : FRAME_LEN;
    localparam int CW        = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_BYTES - 1);
    localparam logic [CW-1:0] FRAME_LAST = CW'(FRAME_LEN - 1);
    localparam logic [CW-1:0] POLL_LAST  = CW'(POLL_LIMIT - 1);
    localparam logic [CW-1:0] TAIL_LAST  = CW'(TAIL_LEN - 1);

    seq_state_e    state_q, state_d;
    sd_cmd_e       cmd_q, cmd_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          wait_q, wait_d;
    logic [7:0]    r1_q, r1_d;
    logic [7:0]    type_q, type_d;
    logic          att_load, att_use, att_last;
    logic          byte_ok, byte_state;
    logic [7:0]    frame_byte;

    sd_cmd_frame u_frame (
        .cmd        (cmd_q),
        .pos        (cnt_q[2:0]),
        .frame_byte (frame_byte)
    );

    sd_attempt_ctr #(.ATTEMPTS(ATTEMPTS)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (att_load),
        .consume (att_use),
        .last    (att_last)
    );

    assign byte_state = (state_q == S_WAKE) || (state_q == S_FRAME) || (state_q == S_POLL) ||
                        (state_q == S_TAIL_RESP) || (state_q == S_RELEASE);
    assign byte_ok    = wait_q && xfer_done;

    // next-state and datapath decisions
    always_comb begin
        state_d  = state_q;
        cmd_d    = cmd_q;
        cnt_d    = cnt_q;
        r1_d     = r1_q;
        type_d   = type_q;
        att_load = 1'b0;
        att_use  = 1'b0;
        wait_d   = byte_state ? (wait_q ? !xfer_done : 1'b1) : 1'b0;
        unique case (state_q)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start) begin
                    att_load = 1'b1;
                    state_d  = S_WAKE;
                    cnt_d    = '0;
                    type_d   = 8'h00;
                end
            end
            S_WAKE: begin
                if (byte_ok) begin
                    if (cnt_q == WAKE_LAST) begin
                        state_d = S_FRAME;
                        cmd_d   = CMD_GO_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            S_FRAME: begin
                if (byte_ok) begin
                    if (cnt_q == FRAME_LAST) begin
                        state_d = S_POLL;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            S_POLL: begin
                if (byte_ok) begin
                    if (!xfer_rx[7]) begin
                        r1_d    = xfer_rx;
                        cnt_d   = '0;
                        state_d = (cmd_q == CMD_IF_COND || cmd_q == CMD_READ_OCR) ? S_TAIL_RESP : S_RELEASE;
                    end else if (cnt_q == POLL_LAST) begin
                        r1_d    = 8'hFF;
                        cnt_d   = '0;
                        state_d = S_RELEASE;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            S_TAIL_RESP: begin
                if (byte_ok) begin
                    if (cnt_q == '0 && cmd_q == CMD_READ_OCR) type_d = xfer_rx;
                    if (cnt_q == TAIL_LAST) begin
                        state_d = S_RELEASE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            S_RELEASE: begin
                if (byte_ok) begin
                    cnt_d = '0;
                    case (cmd_q)
                        CMD_GO_IDLE: begin
                            if (r1_q == 8'h01) begin
                                cmd_d   = CMD_IF_COND;
                                state_d = S_FRAME;
                            end else if (att_last) begin
                                state_d = S_FAIL;
                            end else begin
                                att_use = 1'b1;
                                state_d = S_WAKE;
                            end
                        end
                        CMD_IF_COND: begin
                            cmd_d   = CMD_APP;
                            state_d = S_FRAME;
                        end
                        CMD_APP: begin
                            cmd_d   = CMD_OP_COND;
                            state_d = S_FRAME;
                        end
                        CMD_OP_COND: begin
                            if (r1_q == 8'h00) begin
                                cmd_d   = CMD_READ_OCR;
                                state_d = S_FRAME;
                            end else if (att_last) begin
                                state_d = S_FAIL;
                            end else begin
                                att_use = 1'b1;
                                cmd_d   = CMD_APP;
                                state_d = S_FRAME;
                            end
                        end
                        default: state_d = S_DONE;
                    endcase
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cmd_q   <= CMD_GO_IDLE;
            cnt_q   <= '0;
            wait_q  <= 1'b0;
            r1_q    <= 8'hFF;
            type_q  <= 8'h00;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            cnt_q   <= cnt_d;
            wait_q  <= wait_d;
            r1_q    <= r1_d;
            type_q  <= type_d;
        end
    end

    // outputs
    always_comb begin
        cs_n       = !((state_q == S_FRAME) || (state_q == S_POLL) || (state_q == S_TAIL_RESP));
        xfer_start = byte_state && !wait_q;
        xfer_tx    = (state_q == S_FRAME) ? frame_byte : 8'hFF;
        done       = (state_q == S_DONE);
        error      = (state_q == S_FAIL);
        card_type  = type_q;
    end

endmodule

// File: rtl/sd_spi_init_chk.sv
module sd_spi_init_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       cs_n,
    input logic       xfer_start,
    input logic [7:0] xfer_tx,
    input logic       xfer_done,
    input logic       done,
    input logic       error,
    input logic [7:0] card_type
);

    logic outstanding;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          outstanding <= 1'b0;
        else if (xfer_start) outstanding <= 1'b1;
        else if (xfer_done)  outstanding <= 1'b0;
    end

    p_single_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !xfer_start);

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    p_quiet_after_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!xfer_start && cs_n));

    p_cmd_cs_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && xfer_tx != 8'hFF) |-> !cs_n);

    p_idle_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && cs_n) |-> (xfer_tx == 8'hFF));

    p_type_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(card_type)));

endmodule

bind sd_spi_init sd_spi_init_chk u_chk (.*);

// File: tb/sd_spi_init_tb.sv
module sd_spi_init_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ATT  = 4;
    localparam int WAKE = 10;
    localparam int POLL = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       cs_n, xfer_start, done, error;
    logic [7:0] xfer_tx, card_type;
    logic       xfer_done = 1'b0;
    logic [7:0] xfer_rx = 8'hFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_spi_init #(.ATTEMPTS(ATT), .WAKE_BYTES(WAKE), .POLL_LIMIT(POLL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n),
        .xfer_start(xfer_start), .xfer_tx(xfer_tx), .xfer_done(xfer_done),
        .xfer_rx(xfer_rx), .done(done), .error(error), .card_type(card_type)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scenario knobs, written only by the stimulus process
    int         scen_id = 0;
    int         k_cmd0_bad = 0, k_acmd_busy = 0, k_gap = 0;
    logic       k_silent = 1'b0;
    logic [7:0] k_filler = 8'hFF, k_ocr = 8'h80;

    // card and engine model state, written only by the model process
    logic       pend = 1'b0;
    logic [7:0] p_tx = 8'hFF;
    logic       p_cs = 1'b1;
    int cur_scen = -1;
    int n_bytes = 0, n_cmd0 = 0, n_cmd8 = 0, n_cmd55 = 0, n_cmd41 = 0, n_cmd58 = 0;
    int frame_err = 0, wake_err = 0, seq_err = 0, proto_err = 0;
    int c0 = 0, c41 = 0, fpos = 0, hi_run = 0, post = 0, post_cmd0 = -1, last_idx = -1;
    int rlen = 0, rpos = 0, gap = 0;
    logic seen_first = 1'b0, app_armed = 1'b0, in_cmd = 1'b0;
    logic [7:0] frm [6];
    logic [7:0] resp [5];

    // R3 frame contents, from the requirement text
    function automatic logic [7:0] exp_byte(input int idx, input int k);
        logic [7:0] f [6];
        case (idx)
            0:  f = '{8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h95};
            8:  f = '{8'h48, 8'h00, 8'h00, 8'h01, 8'hAA, 8'h87};
            55: f = '{8'h77, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01};
            41: f = '{8'h69, 8'h40, 8'h00, 8'h00, 8'h00, 8'h01};
            58: f = '{8'h7A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01};
            default: f = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        endcase
        return f[k];
    endfunction

    task automatic frame_end();
        int idx;
        idx = int'(frm[0][5:0]);
        for (int k = 0; k < 6; k++) if (frm[k] != exp_byte(idx, k)) frame_err++;
        last_idx = idx;
        rpos = 0;
        rlen = 1;
        gap = k_gap;
        case (idx)
            0: begin
                n_cmd0++;
                if (c0 < k_cmd0_bad) begin
                    if (k_silent) rlen = 0;
                    else resp[0] = 8'h05;
                end else resp[0] = 8'h01;
                c0++;
            end
            8: begin
                n_cmd8++;
                resp = '{8'h01, 8'h00, 8'h00, 8'h01, 8'hAA};
                rlen = 5;
            end
            55: begin
                n_cmd55++;
                app_armed = 1'b1;
                resp[0] = 8'h01;
            end
            41: begin
                n_cmd41++;
                if (!app_armed) seq_err++;
                app_armed = 1'b0;
                resp[0] = (c41 < k_acmd_busy) ? 8'h01 : 8'h00;
                c41++;
            end
            58: begin
                n_cmd58++;
                resp = '{8'h00, k_ocr, 8'hFF, 8'h80, 8'h00};
                rlen = 5;
            end
            default: begin
                frame_err++;
                rlen = 0;
            end
        endcase
    endtask

    task automatic model_byte(input logic [7:0] tx, input logic cs, output logic [7:0] rx);
        int want;
        if (scen_id != cur_scen) begin
            cur_scen = scen_id;
            c0 = 0; c41 = 0; fpos = 0; rlen = 0; rpos = 0; gap = 0; hi_run = 0;
            seen_first = 1'b0; app_armed = 1'b0; in_cmd = 1'b0;
            post = 0; post_cmd0 = -1; last_idx = -1;
        end
        n_bytes++;
        rx = 8'hFF;
        if (cs) begin
            if (in_cmd) begin
                if (last_idx == 0) post_cmd0 = post;
                in_cmd = 1'b0;
            end
            if (tx != 8'hFF) proto_err++;
            hi_run++;
            fpos = 0;
            rlen = 0;
        end else if (fpos == 0 && !in_cmd && tx[7:6] == 2'b01) begin
            // R2/R9: count of chip-select-high bytes ahead of this frame
            if (!seen_first)            want = WAKE;
            else if (tx[5:0] == 6'd0)   want = WAKE + 1;
            else                        want = 1;
            if (hi_run != want) wake_err++;
            seen_first = 1'b1;
            hi_run = 0;
            frm[0] = tx;
            fpos = 1;
        end else if (fpos > 0) begin
            frm[fpos] = tx;
            fpos++;
            if (fpos == 6) begin
                fpos = 0;
                frame_end();
                in_cmd = 1'b1;
                post = 0;
            end
        end else begin
            post++;
            if (tx != 8'hFF) proto_err++;
            if (gap > 0) begin
                gap--;
                rx = k_filler;
            end else if (rpos < rlen) begin
                rx = resp[rpos];
                rpos++;
            end
        end
    endtask

    // SPI byte engine plus card
    always @(posedge clk) begin
        logic [7:0] r;
        xfer_done <= 1'b0;
        if (xfer_start && (pend || xfer_done)) proto_err++;
        if (pend) begin
            model_byte(p_tx, p_cs, r);
            xfer_rx   <= r;
            xfer_done <= 1'b1;
            pend      <= 1'b0;
        end else if (xfer_start) begin
            p_tx <= xfer_tx;
            p_cs <= cs_n;
            pend <= 1'b1;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R10 actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int b0, b41, b55, b58, b8, bf, bw, bs, bp, nb;
        int exp_err, e0, e41, e58, e8, rem, exp_post, waited;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset cs_n", int'(cs_n), 1);
        check("R1 reset xfer_start", int'(xfer_start), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset error", int'(error), 0);
        check("R1 reset card_type", int'(card_type), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check("R1 idle no transfers", n_bytes, 0);

        for (int b = 0; b <= ATT; b++) begin
            for (int a = 0; a <= ATT; a++) begin
                k_cmd0_bad  = b;
                k_acmd_busy = a;
                k_gap       = (b + 2 * a) % 3;
                k_silent    = (a % 2) == 1;
                k_filler    = ((a + b) % 2 == 1) ? 8'hA5 : 8'hFF;
                k_ocr       = ((a + b) % 2 == 0) ? 8'h80 : 8'hC0;
                scen_id++;
                b0 = n_cmd0; b8 = n_cmd8; b41 = n_cmd41; b55 = n_cmd55; b58 = n_cmd58;
                bf = frame_err; bw = wake_err; bs = seq_err; bp = proto_err;

                @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check("R11 card_type cleared on start", int'(card_type), 0);
                check("R11 restart leaves terminal", int'(done | error), 0);

                waited = 0;
                while (!(done || error) && waited < 20000) begin
                    @(negedge clk);
                    waited++;
                end
                check("R7 sequence finished", int'(waited < 20000), 1);

                if (b >= ATT) begin
                    exp_err = 1; e0 = ATT; e8 = 0; e41 = 0; e58 = 0;
                end else begin
                    rem = ATT - b;
                    e0 = b + 1;
                    e8 = 1;
                    if (a >= rem) begin
                        exp_err = 1; e41 = rem; e58 = 0;
                    end else begin
                        exp_err = 0; e41 = a + 1; e58 = 1;
                    end
                end
                exp_post = (b >= ATT && k_silent) ? POLL : k_gap + 1;

                check("R7 error flag", int'(error), exp_err);
                check("R8 done flag", int'(done), 1 - exp_err);
                check("R8 card_type", int'(card_type), exp_err ? 0 : int'(k_ocr));
                check("R5 go-idle count", n_cmd0 - b0, e0);
                check("R5 if-cond count", n_cmd8 - b8, e8);
                check("R6 app-init count", n_cmd41 - b41, e41);
                check("R6 app-prefix count", n_cmd55 - b55, e41);
                check("R6 prefix precedes init", seq_err - bs, 0);
                check("R8 read-OCR count", n_cmd58 - b58, e58);
                check("R3 frame bytes", frame_err - bf, 0);
                check("R2 R9 chip-select-high runs", wake_err - bw, 0);
                check("R10 handshake", proto_err - bp, 0);
                check("R4 poll length after last go-idle", post_cmd0, exp_post);

                nb = n_bytes;
                repeat (40) @(negedge clk);
                check("R7 R8 no transfers after end", n_bytes - nb, 0);
                check("R8 terminal state held", int'(done | error), 1);
                check("R9 cs_n high at end", int'(cs_n), 1);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule